// File: doc/BRIEF.md
# Wrapper Instruction Register Controller

This block is the instruction side of a core test wrapper. A short instruction is loaded over a serial port made of a serial input, a serial output, a path select and three strobes: capture, shift and update. The instruction has two stages. A shift stage moves bits from the serial input toward the serial output. An update stage copies the shift stage only when an update strobe arrives while the instruction path is selected, so the active instruction never shows partly shifted bits.

The active instruction is decoded into a wrapper mode: functional pass-through, inward core test, serial external test, isolation or bypass. The mode then sets three things: the control levels sent to the input and output boundary cells, which data register sits between serial in and serial out when the data path is selected, and whether data-path strobes are passed on to the boundary register or to the core chain. A small phase tracker runs inside the two test modes. It shows whether the last data operation was a capture, a shift or an apply (update), and raises a test-apply flag after a data update.

When the path select is low and the mode is not a test mode, a one-bit bypass register inside the block gives a short serial path through the wrapper.

Top module: `wir_ctrl`

## Requirements
- R1: Asserting the active-low reset asynchronously returns the wrapper to functional mode: `mode_o` = 5'b00001, `dr_sel_o` = 0, both cell controls low, `test_apply_o` low and the bypass bit cleared. Internal release of reset waits for two rising clock edges after `rst_n` goes high.
- R2: With `ir_sel_i` high, `cap_i` loads the pattern 3'b001 into the instruction shift stage. Capture has priority over shift, and shift has priority over update.
- R3: With `ir_sel_i` high and `shift_i` high (capture low), the shift stage moves one place toward bit 0 and `ser_in_i` enters at bit 2. While `ir_sel_i` is high, `ser_out_o` shows shift-stage bit 0, so instructions go in and come out LSB first.
- R4: Capturing into or shifting the instruction shift stage never changes the active instruction, the mode or any mode-derived output.
- R5: An update with `ir_sel_i` high (capture and shift low) copies the shift stage into the active instruction. From the next cycle the mode is decoded from it: 000 functional (`mode_o` bit 0), 001 bypass (bit 1), 010 core test (bit 2), 011 external test (bit 3), 100 isolation (bit 4). Codes 101, 110 and 111 decode to bypass. `mode_o` always has exactly one bit set.
- R6: An update strobe while `ir_sel_i` is low does not change the active instruction or the mode.
- R7: With `ir_sel_i` low, `ser_out_o` comes from the data register named by `dr_sel_o`: 0 bypass bit, 1 boundary register (`bdy_so_i`), 2 core chain (`core_so_i`). Core test selects 2, external test selects 1, and every other mode selects 0.
- R8: The bypass bit is active when `ir_sel_i` is low and `dr_sel_o` is 0. Capture clears it, and shift loads `ser_in_i`, so data passes through with a one-shift delay.
- R9: `wc_in_test_o` (core inputs driven by the wrapper) is high in core test and in isolation. `wc_out_test_o` (system-side outputs driven by the wrapper) is high in external test and in isolation. Both are low otherwise.
- R10: `dr_capture_o`, `dr_shift_o` and `dr_update_o` repeat the capture, shift and update strobes, using the same priority, only while `ir_sel_i` is low and the mode is core test or external test. Otherwise they are low.
- R11: In a test mode, `test_apply_o` goes high on the cycle after a data-path update. It falls after the next data-path capture or shift, or after any instruction update. It is always low outside the two test modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in_i | input | 1 | Serial test input |
| ir_sel_i | input | 1 | 1: serial path through instruction register, 0: through data register |
| cap_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| bdy_so_i | input | 1 | Serial output of boundary register |
| core_so_i | input | 1 | Serial output of core scan chain |
| ser_out_o | output | 1 | Serial test output |
| mode_o | output | 5 | One-hot mode: functional, bypass, core test, external test, isolation |
| dr_sel_o | output | 2 | Selected data register |
| wc_in_test_o | output | 1 | Input cells drive the core |
| wc_out_test_o | output | 1 | Output cells drive the system |
| dr_capture_o | output | 1 | Capture strobe to selected test register |
| dr_shift_o | output | 1 | Shift strobe to selected test register |
| dr_update_o | output | 1 | Update strobe to selected test register |
| test_apply_o | output | 1 | Test values applied after data update |

## Verification
The bench first loads each of the eight codes, including the three unused ones. A decoder that left unused codes unmapped, or mapped them to functional mode, would give a wrong or zero `mode_o` there. Random strobe mixes then put the strobes together in the same cycle and place updates on the data path. A design with the wrong capture, shift and update priority, or one that let a data update touch the instruction, would then show a wrong mode or a wrong serial-out bit. Long shift runs check that the mode stays still while bits move. A reset asserted in the middle of the run checks that the return to functional mode is asynchronous and that the bypass bit clears.

// File: rtl/wir_pkg.sv
package wir_pkg;

  localparam int IR_W    = 3;
  localparam int MODE_N  = 5;
  localparam int DRSEL_W = 2;

  typedef enum logic [IR_W-1:0] {
    OP_NORMAL  = 3'd0,
    OP_BYPASS  = 3'd1,
    OP_INTEST  = 3'd2,
    OP_EXTEST  = 3'd3,
    OP_ISOLATE = 3'd4
  } opcode_e;

  typedef enum logic [2:0] {
    MD_NORMAL  = 3'd0,
    MD_BYPASS  = 3'd1,
    MD_INTEST  = 3'd2,
    MD_EXTEST  = 3'd3,
    MD_ISOLATE = 3'd4
  } mode_e;

  typedef enum logic [DRSEL_W-1:0] {
    DR_BYPASS   = 2'd0,
    DR_BOUNDARY = 2'd1,
    DR_CORE     = 2'd2
  } drsel_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_SHIFT   = 2'd2,
    PH_APPLY   = 2'd3
  } phase_e;

  function automatic mode_e op_to_mode(input logic [IR_W-1:0] op);
    mode_e m;
    case (op)
      OP_NORMAL:  m = MD_NORMAL;
      OP_BYPASS:  m = MD_BYPASS;
      OP_INTEST:  m = MD_INTEST;
      OP_EXTEST:  m = MD_EXTEST;
      OP_ISOLATE: m = MD_ISOLATE;
      default:    m = MD_BYPASS;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/wir_ir.sv
module wir_ir
  import wir_pkg::*;
#(
  parameter int             W       = IR_W,
  parameter logic [W-1:0]   CAP_PAT = 3'b001,
  parameter logic [W-1:0]   RST_OP  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         si,
  input  logic         sel,
  input  logic         cap,
  input  logic         shf,
  input  logic         upd,
  output logic [W-1:0] shift_q,
  output logic [W-1:0] active_q,
  output logic         upd_evt
);

  logic         cap_en;
  logic         shf_en;
  logic [W-1:0] shift_d;
  logic [W-1:0] active_d;

  always_comb begin
    cap_en  = sel & cap;
    shf_en  = sel & shf & ~cap;
    upd_evt = sel & upd & ~cap & ~shf;
  end

  always_comb begin
    shift_d = shift_q;
    if (cap_en) begin
      shift_d = CAP_PAT;
    end else if (shf_en) begin
      shift_d = {si, shift_q[W-1:1]};
    end
  end

  always_comb begin
    active_d = active_q;
    if (upd_evt) begin
      active_d = shift_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      active_q <= RST_OP;
    end else begin
      shift_q  <= shift_d;
      active_q <= active_d;
    end
  end

  // R2: capture loads the fixed pattern
  p_ir_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cap) |=> (shift_q == CAP_PAT));

  // R3: shift moves toward bit 0 with serial input at the top
  p_ir_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shf && !cap) |=> (shift_q == {$past(si), $past(shift_q[W-1:1])}));

  // R6: no instruction-path update means the active instruction holds
  p_ir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && upd) |=> $stable(active_q));

endmodule

// File: rtl/wir_mode_fsm.sv
module wir_mode_fsm
  import wir_pkg::*;
#(
  parameter int W = IR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_evt,
  input  logic [W-1:0] next_op,
  input  logic         sel,
  input  logic         cap,
  input  logic         shf,
  input  logic         upd,
  output mode_e        mode_q,
  output phase_e       phase_q
);

  mode_e  mode_d;
  phase_e phase_d;
  logic   in_test;
  logic   d_cap;
  logic   d_shf;
  logic   d_upd;

  always_comb begin
    in_test = (mode_q == MD_INTEST) || (mode_q == MD_EXTEST);
    d_cap   = ~sel & cap;
    d_shf   = ~sel & shf & ~cap;
    d_upd   = ~sel & upd & ~cap & ~shf;
  end

  always_comb begin
    mode_d = mode_q;
    if (upd_evt) begin
      mode_d = op_to_mode(next_op);
    end
  end

  always_comb begin
    phase_d = phase_q;
    if (upd_evt || !in_test) begin
      phase_d = PH_IDLE;
    end else if (d_cap) begin
      phase_d = PH_CAPTURE;
    end else if (d_shf) begin
      phase_d = PH_SHIFT;
    end else if (d_upd) begin
      phase_d = PH_APPLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_NORMAL;
      phase_q <= PH_IDLE;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
    end
  end

  // R4: mode moves only on an instruction update
  p_mode_only_on_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(mode_q));

  // R11: apply phase exists only inside a test mode
  p_apply_in_test_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_APPLY) |-> in_test);

endmodule

// File: rtl/wir_decode.sv
module wir_decode
  import wir_pkg::*;
#(
  parameter int N = MODE_N
) (
  input  mode_e        mode,
  output logic [N-1:0] mode_oh,
  output drsel_e       drsel,
  output logic         in_test,
  output logic         out_test,
  output logic         dr_active
);

  for (genvar i = 0; i < N; i++) begin : g_oh
    assign mode_oh[i] = (int'(mode) == i);
  end

  always_comb begin
    drsel     = DR_BYPASS;
    in_test   = 1'b0;
    out_test  = 1'b0;
    dr_active = 1'b0;
    case (mode)
      MD_INTEST: begin
        drsel     = DR_CORE;
        in_test   = 1'b1;
        dr_active = 1'b1;
      end
      MD_EXTEST: begin
        drsel     = DR_BOUNDARY;
        out_test  = 1'b1;
        dr_active = 1'b1;
      end
      MD_ISOLATE: begin
        in_test  = 1'b1;
        out_test = 1'b1;
      end
      default: begin
        drsel = DR_BYPASS;
      end
    endcase
  end

  // R5: exactly one mode bit is active
  always_comb begin
    p_onehot_r5: assert ($countones(mode_oh) == 1);
  end

endmodule

// File: rtl/wir_serial_path.sv
module wir_serial_path
  import wir_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   si,
  input  logic   sel,
  input  logic   cap,
  input  logic   shf,
  input  drsel_e drsel,
  input  logic   ir_so,
  input  logic   bdy_so,
  input  logic   core_so,
  output logic   so
);

  logic byp_q;
  logic byp_d;
  logic byp_en;
  logic dr_so;

  always_comb begin
    byp_en = ~sel & (drsel == DR_BYPASS);
    byp_d  = byp_q;
    if (byp_en) begin
      if (cap) begin
        byp_d = 1'b0;
      end else if (shf) begin
        byp_d = si;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else begin
      byp_q <= byp_d;
    end
  end

  always_comb begin
    case (drsel)
      DR_BOUNDARY: dr_so = bdy_so;
      DR_CORE:     dr_so = core_so;
      default:     dr_so = byp_q;
    endcase
    so = sel ? ir_so : dr_so;
  end

  // R8: bypass bit delays serial input by one shift
  p_bypass_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && shf && !cap && drsel == DR_BYPASS) |=> (byp_q == $past(si)));

  // R8: bypass capture clears the bit
  p_bypass_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && cap && drsel == DR_BYPASS) |=> !byp_q);

endmodule

// File: rtl/wir_ctrl.sv
module wir_ctrl
  import wir_pkg::*;
#(
  parameter logic [IR_W-1:0] CAP_PAT = 3'b001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in_i,
  input  logic               ir_sel_i,
  input  logic               cap_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               bdy_so_i,
  input  logic               core_so_i,
  output logic               ser_out_o,
  output logic [MODE_N-1:0]  mode_o,
  output logic [DRSEL_W-1:0] dr_sel_o,
  output logic               wc_in_test_o,
  output logic               wc_out_test_o,
  output logic               dr_capture_o,
  output logic               dr_shift_o,
  output logic               dr_update_o,
  output logic               test_apply_o
);

  logic            rst_meta_q;
  logic            rst_sync_q;
  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_active;
  logic            ir_upd_evt;
  mode_e           mode;
  phase_e          phase;
  drsel_e          drsel;
  logic            dr_active;

  // R1: asynchronous assertion, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wir_ir #(
    .W       (IR_W),
    .CAP_PAT (CAP_PAT),
    .RST_OP  (OP_NORMAL)
  ) u_ir (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .si       (ser_in_i),
    .sel      (ir_sel_i),
    .cap      (cap_i),
    .shf      (shift_i),
    .upd      (update_i),
    .shift_q  (ir_shift),
    .active_q (ir_active),
    .upd_evt  (ir_upd_evt)
  );

  wir_mode_fsm #(
    .W (IR_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .upd_evt (ir_upd_evt),
    .next_op (ir_shift),
    .sel     (ir_sel_i),
    .cap     (cap_i),
    .shf     (shift_i),
    .upd     (update_i),
    .mode_q  (mode),
    .phase_q (phase)
  );

  wir_decode #(
    .N (MODE_N)
  ) u_dec (
    .mode      (mode),
    .mode_oh   (mode_o),
    .drsel     (drsel),
    .in_test   (wc_in_test_o),
    .out_test  (wc_out_test_o),
    .dr_active (dr_active)
  );

  wir_serial_path u_path (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .si      (ser_in_i),
    .sel     (ir_sel_i),
    .cap     (cap_i),
    .shf     (shift_i),
    .drsel   (drsel),
    .ir_so   (ir_shift[0]),
    .bdy_so  (bdy_so_i),
    .core_so (core_so_i),
    .so      (ser_out_o)
  );

  always_comb begin
    dr_sel_o     = drsel;
    dr_capture_o = dr_active & ~ir_sel_i & cap_i;
    dr_shift_o   = dr_active & ~ir_sel_i & shift_i & ~cap_i;
    dr_update_o  = dr_active & ~ir_sel_i & update_i & ~cap_i & ~shift_i;
    test_apply_o = (phase == PH_APPLY);
  end

  // R5: active mode always agrees with the active instruction
  p_mode_tracks_ir_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mode == op_to_mode(ir_active));

  // R10: forwarded shift only on a data-path shift
  p_dr_shift_gate_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    dr_shift_o |-> (!ir_sel_i && shift_i && !cap_i));

  // R10: forwarded strobes are mutually exclusive
  p_dr_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones({dr_capture_o, dr_shift_o, dr_update_o}) <= 1);

  // R11: apply flag only after a data-path update
  p_apply_rise_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(test_apply_o) |-> $past(dr_update_o));

endmodule

// File: tb/wir_ctrl_bench.sv
module wir_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_in_i, ir_sel_i, cap_i, shift_i, update_i, bdy_so_i, core_so_i;
  logic       ser_out_o;
  logic [4:0] mode_o;
  logic [1:0] dr_sel_o;
  logic       wc_in_test_o, wc_out_test_o;
  logic       dr_capture_o, dr_shift_o, dr_update_o, test_apply_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model
  logic [2:0] m_sh;
  logic [2:0] m_act;
  logic       m_byp;
  int         m_ph;   // 0 idle, 1 capture, 2 shift, 3 apply

  always #5 clk = ~clk;

  wir_ctrl u_wir_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_in_i      (ser_in_i),
    .ir_sel_i      (ir_sel_i),
    .cap_i         (cap_i),
    .shift_i       (shift_i),
    .update_i      (update_i),
    .bdy_so_i      (bdy_so_i),
    .core_so_i     (core_so_i),
    .ser_out_o     (ser_out_o),
    .mode_o        (mode_o),
    .dr_sel_o      (dr_sel_o),
    .wc_in_test_o  (wc_in_test_o),
    .wc_out_test_o (wc_out_test_o),
    .dr_capture_o  (dr_capture_o),
    .dr_shift_o    (dr_shift_o),
    .dr_update_o   (dr_update_o),
    .test_apply_o  (test_apply_o)
  );

  function automatic int f_mode(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 3;
      3'd4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int f_dr(input int m);
    if (m == 2) return 2;
    if (m == 3) return 1;
    return 0;
  endfunction

  function automatic bit f_is_test(input int m);
    return (m == 2) || (m == 3);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sh  = 3'b000;
    m_act = 3'b000;
    m_byp = 1'b0;
    m_ph  = 0;
  endtask

  task automatic check_outputs();
    int m;
    int d;
    int exp_so;
    bit t;
    m = f_mode(m_act);
    d = f_dr(m);
    t = f_is_test(m);
    chk("R5", "mode_o", int'(mode_o), 1 << m);
    chk("R7", "dr_sel_o", int'(dr_sel_o), d);
    chk("R9", "wc_in_test_o", int'(wc_in_test_o), int'((m == 2) || (m == 4)));
    chk("R9", "wc_out_test_o", int'(wc_out_test_o), int'((m == 3) || (m == 4)));
    chk("R10", "dr_capture_o", int'(dr_capture_o), int'(t && !ir_sel_i && cap_i));
    chk("R10", "dr_shift_o", int'(dr_shift_o), int'(t && !ir_sel_i && shift_i && !cap_i));
    chk("R10", "dr_update_o", int'(dr_update_o),
        int'(t && !ir_sel_i && update_i && !cap_i && !shift_i));
    chk("R11", "test_apply_o", int'(test_apply_o), int'(m_ph == 3));
    if (ir_sel_i) exp_so = int'(m_sh[0]);
    else if (d == 1) exp_so = int'(bdy_so_i);
    else if (d == 2) exp_so = int'(core_so_i);
    else exp_so = int'(m_byp);
    chk(ir_sel_i ? "R3" : "R8", "ser_out_o", int'(ser_out_o), exp_so);
  endtask

  task automatic model_step();
    int  m;
    bit  t;
    bit  ir_upd;
    m = f_mode(m_act);
    t = f_is_test(m);
    ir_upd = ir_sel_i && update_i && !cap_i && !shift_i;
    if (ir_sel_i) begin
      if (cap_i) m_sh = 3'b001;
      else if (shift_i) m_sh = {ser_in_i, m_sh[2:1]};
      else if (update_i) m_act = m_sh;
    end else if (f_dr(m) == 0) begin
      if (cap_i) m_byp = 1'b0;
      else if (shift_i) m_byp = ser_in_i;
    end
    if (ir_upd || !t) m_ph = 0;
    else if (!ir_sel_i && cap_i) m_ph = 1;
    else if (!ir_sel_i && shift_i) m_ph = 2;
    else if (!ir_sel_i && update_i) m_ph = 3;
  endtask

  task automatic step(input logic s, input logic c, input logic sh,
                      input logic u, input logic din);
    @(negedge clk);
    ir_sel_i  = s;
    cap_i     = c;
    shift_i   = sh;
    update_i  = u;
    ser_in_i  = din;
    bdy_so_i  = $urandom_range(0, 1);
    core_so_i = $urandom_range(0, 1);
    #1;
    check_outputs();
    @(posedge clk);
    model_step();
  endtask

  task automatic load_ir(input logic [2:0] code);
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, code[i]);
    step(1, 0, 0, 1, 0);
  endtask

  task automatic idle_release();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; ir_sel_i = 0; cap_i = 0; shift_i = 0; update_i = 0;
    ser_in_i = 0; bdy_so_i = 0; core_so_i = 0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "mode_o reset", int'(mode_o), 1);
    chk("R1", "test_apply_o reset", int'(test_apply_o), 0);
    chk("R1", "ser_out_o reset", int'(ser_out_o), 0);
    idle_release();

    // R2 R3: capture then read the pattern out LSB first, no mode change (R4)
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 1);
    chk("R4", "mode_o after shifting", int'(mode_o), 1);

    // R5: every code, unused ones included
    for (int c = 0; c < 8; c++) begin
      load_ir(c[2:0]);
      step(0, 0, 0, 0, 0);
      chk("R5", "mode after load", int'(mode_o), 1 << f_mode(c[2:0]));
    end

    // R8: bypass pass-through in bypass mode
    load_ir(3'b001);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 1);

    // R11 R6: test apply in external test, data update leaves mode alone
    load_ir(3'b011);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    chk("R11", "apply after data update", int'(test_apply_o), 1);
    chk("R6", "mode after data update", int'(mode_o), 1 << 3);
    // R2: simultaneous strobes on instruction path, capture wins
    step(1, 1, 1, 1, 1);
    step(1, 0, 0, 0, 0);
    chk("R2", "mode after combined strobes", int'(mode_o), 1 << 3);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      step(($urandom_range(0, 99) < 45), ($urandom_range(0, 99) < 15),
           ($urandom_range(0, 99) < 50), ($urandom_range(0, 99) < 25),
           $urandom_range(0, 1));
    end

    // R1: asynchronous reset mid-run
    load_ir(3'b100);
    @(negedge clk);
    rst_n = 1'b0;
    ir_sel_i = 0; cap_i = 0; shift_i = 0; update_i = 0;
    #1;
    model_reset();
    chk("R1", "mode_o async reset", int'(mode_o), 1);
    chk("R1", "wc_in_test_o async reset", int'(wc_in_test_o), 0);
    chk("R1", "wc_out_test_o async reset", int'(wc_out_test_o), 0);
    idle_release();
    for (int k = 0; k < 500; k++) begin
      step($urandom_range(0, 1), ($urandom_range(0, 99) < 10),
           $urandom_range(0, 1), ($urandom_range(0, 99) < 30),
           $urandom_range(0, 1));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule